// File: doc/BRIEF.md
# Level-Sensitive Interrupt Selector

This block gathers 64 level-sensitive interrupt inputs and presents them to one processor as a single request line. Each input has its own small configuration word, reached through a plain register port. An input takes part only while its configuration word holds the enable code. Software turns an input off by writing zero to that word.

When software services the request line, it reads one selection word. That word reports whether any enabled input is asserted and, if so, which one. When several inputs are asserted together, the selection word names the lowest-numbered one.

A build parameter picks one of two variants. The variant fixes the enable code and the address of the selection word. The configuration words, the enable decoding, the pending logic and the fixed-order pick all live in this block. The processor request and the selection word follow the inputs in the same cycle, with no register in between.

Top module: `irq_select_ctrl`

## Requirements
- R1: After reset every configuration word reads 0, so every source starts disabled. The request output is 0 and the selection word reads 0, whatever the source inputs are.
- R2: The configuration word of source n (0..63) sits at byte address 4*n. A write stores bits 6:0 of the write data. A read returns those 7 bits in bits 6:0, with bits 31:7 equal to 0.
- R3: A source is enabled only while its 7-bit field equals the variant's enable code: 0x51 for VARIANT 0 and 0x20 for VARIANT 1. Any other value, including a code that differs by one bit, leaves it disabled.
- R4: Writing 0 to a source's field disables it. The source then no longer raises the request, even with its input high.
- R5: The selection word sits at byte address 0x10C for VARIANT 0 and at 0x104 for VARIANT 1. Bit 6 is 1 when an enabled source is pending. Bits 5:0 hold that source's number, and bits 31:7 read 0.
- R6: When several enabled sources are pending together, the selection word reports the lowest-numbered one.
- R7: The request output is the OR of all enabled, asserted sources. It follows a change on the source inputs in the same cycle.
- R8: Sources are level-sensitive. A source counts as pending only while its input is high, and the pending state clears as soon as the input falls.
- R9: A write to the selection word, to an address above the last configuration word, or to an address with bits 1:0 not zero changes no configuration word. A read of any address that maps to nothing returns 0.
- R10: With no enabled source pending, the selection word reads exactly 0: bit 6 is 0 and bits 5:0 are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| src_level | input | 64 | Level-sensitive interrupt inputs, one bit per source |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The bench drives a VARIANT 0 instance and a VARIANT 1 instance from the same bus, so each enable code has to work in one instance and be refused in the other. It also writes 0x50, one bit away from the code; a design that matched on a mask instead of the exact code would wrongly enable that source. Pending sets at 63, at {40, 63} and at {0, 63} test the fixed-order pick; a reversed or off-by-one encoder reports the wrong source number. Writes to the selection word, to address 0x100 just past the last configuration word, and to an unaligned address test for aliasing; a decoder that drops the upper or lower address bits would overwrite source 0.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    localparam int CFG_W = 7;

    typedef enum logic [1:0] {
        DEC_NONE = 2'd0,
        DEC_CFG  = 2'd1,
        DEC_SEL  = 2'd2
    } dec_kind_e;

    // Enable code per variant
    function automatic logic [CFG_W-1:0] enable_code(input int variant);
        return (variant == 0) ? 7'h51 : 7'h20;
    endfunction

    // Byte address of the selection word per variant
    function automatic int sel_offset(input int variant);
        return (variant == 0) ? 32'h10C : 32'h104;
    endfunction

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_sel_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_SRC    = 64,
    parameter int IDX_W      = 6,
    parameter int SEL_OFFSET = 32'h10C
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(SEL_OFFSET);
    localparam logic [ADDR_W-3:0] WORD_LIM = (ADDR_W-2)'(NUM_SRC);

    logic [ADDR_W-3:0] word_idx;
    logic              aligned;

    assign word_idx = addr[ADDR_W-1:2];
    assign aligned  = (addr[1:0] == 2'b00);
    assign idx      = word_idx[IDX_W-1:0];

    always_comb begin
        kind = DEC_NONE;
        if (addr == SEL_ADDR) begin
            kind = DEC_SEL;
        end else if (aligned && (word_idx < WORD_LIM)) begin
            kind = DEC_CFG;
        end
    end
endmodule

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank #(
    parameter int              NUM_SRC     = 64,
    parameter int              IDX_W       = 6,
    parameter int              CFG_W       = 7,
    parameter logic [CFG_W-1:0] ENABLE_CODE = 7'h51
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [CFG_W-1:0]   wr_val,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [CFG_W-1:0]   rd_val,
    output logic [NUM_SRC-1:0] en_vec
);
    logic [CFG_W-1:0] cfg_q [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                cfg_q[g] <= wr_val;
            end
        end
        assign en_vec[g] = (cfg_q[g] == ENABLE_CODE);
    end

    assign rd_val = cfg_q[rd_idx];

    // R3: only the exact code turns a source on
    a_r3_code_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_val == ENABLE_CODE) |=> en_vec[$past(wr_idx)]);
    a_r3_other_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_val != ENABLE_CODE) |=> !en_vec[$past(wr_idx)]);
    // R4: zero write leaves the source off
    a_r4_zero_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_val == '0) |=> !en_vec[$past(wr_idx)]);
    // R2: written value reads back on the next cycle at the same index
    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_idx == wr_idx) ##1 (rd_idx == $past(wr_idx)) |-> rd_val == $past(wr_val));
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int NUM_SRC = 64,
    parameter int IDX_W   = 6
) (
    input  logic [NUM_SRC-1:0] active,
    output logic               valid,
    output logic [IDX_W-1:0]   idx
);
    // Scan from the top down so the lowest asserted index is kept
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (active[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_select_ctrl.sv
module irq_select_ctrl
    import irq_sel_pkg::*;
#(
    parameter int VARIANT = 0,
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_SRC-1:0] src_level,
    output logic               cpu_irq
);
    localparam int               IDX_W       = $clog2(NUM_SRC);
    localparam logic [CFG_W-1:0] EN_CODE     = enable_code(VARIANT);
    localparam int               SEL_OFFSET  = sel_offset(VARIANT);

    dec_kind_e          kind;
    logic [IDX_W-1:0]   dec_idx;
    logic [CFG_W-1:0]   cfg_rd;
    logic [NUM_SRC-1:0] en_vec;
    logic [NUM_SRC-1:0] active;
    logic               pick_valid;
    logic [IDX_W-1:0]   pick_idx;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CFG_W];

    irq_addr_decode #(
        .ADDR_W     (ADDR_W),
        .NUM_SRC    (NUM_SRC),
        .IDX_W      (IDX_W),
        .SEL_OFFSET (SEL_OFFSET)
    ) u_decode (
        .addr (reg_addr),
        .kind (kind),
        .idx  (dec_idx)
    );

    irq_cfg_bank #(
        .NUM_SRC     (NUM_SRC),
        .IDX_W       (IDX_W),
        .CFG_W       (CFG_W),
        .ENABLE_CODE (EN_CODE)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr && (kind == DEC_CFG)),
        .wr_idx (dec_idx),
        .wr_val (reg_wdata[CFG_W-1:0]),
        .rd_idx (dec_idx),
        .rd_val (cfg_rd),
        .en_vec (en_vec)
    );

    assign active  = en_vec & src_level;
    assign cpu_irq = |active;

    irq_lowest_pick #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_pick (
        .active (active),
        .valid  (pick_valid),
        .idx    (pick_idx)
    );

    always_comb begin
        unique case (kind)
            DEC_CFG: reg_rdata = {{(DATA_W-CFG_W){1'b0}}, cfg_rd};
            DEC_SEL: reg_rdata = {{(DATA_W-IDX_W-1){1'b0}}, pick_valid, pick_idx};
            default: reg_rdata = '0;
        endcase
    end

    // R7: OR-reduced request agrees with the encoder's pending flag
    a_r7_irq_vs_pick: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == pick_valid);
    // R6: the chosen source is pending and nothing below it is
    a_r6_pick_pending: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> active[pick_idx]);
    a_r6_none_lower: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> ((active & ~({NUM_SRC{1'b1}} << pick_idx)) == '0));
    // R10: idle selection word is all zero
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |-> (!pick_valid && pick_idx == '0));
    // R5: pending flag read through the port matches the request line
    a_r5_sel_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == DEC_SEL) |-> (reg_rdata[IDX_W] == cpu_irq));
endmodule

// File: tb/irq_select_ctrl_bench.sv
`timescale 1ns/1ps
module irq_select_ctrl_bench;

    typedef struct {
        logic [31:0] rd;
        logic        irq;
        bit          inst;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [63:0] src_level = '0;
    logic [31:0] rd_a, rd_b;
    logic        irq_a, irq_b;

    exp_t        sb[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [6:0]  cfg_m [2][64];

    always #4 clk = ~clk;

    irq_select_ctrl #(.VARIANT(0)) u_irq_select_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(rd_a), .src_level(src_level), .cpu_irq(irq_a));

    irq_select_ctrl #(.VARIANT(1)) u_irq_select_ctrl_alt (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(rd_b), .src_level(src_level), .cpu_irq(irq_b));

    function automatic bit en_m(bit inst, int i);
        return cfg_m[inst][i] == (inst ? 7'h20 : 7'h51);
    endfunction

    function automatic logic [31:0] sel_m(bit inst, logic [63:0] src);
        for (int i = 0; i < 64; i++)
            if (en_m(inst, i) && src[i]) return {25'd0, 1'b1, 6'(i)};
        return 32'd0;
    endfunction

    function automatic logic irq_m(bit inst, logic [63:0] src);
        for (int i = 0; i < 64; i++)
            if (en_m(inst, i) && src[i]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] rd_m(bit inst, logic [11:0] a, logic [63:0] src);
        if (a == (inst ? 12'h104 : 12'h10C)) return sel_m(inst, src);
        if (a[1:0] == 2'b00 && a < 12'h100) return {25'd0, cfg_m[inst][a[7:2]]};
        return 32'd0;
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        if (a[1:0] == 2'b00 && a < 12'h100) begin
            cfg_m[0][a[7:2]] = d[6:0];
            cfg_m[1][a[7:2]] = d[6:0];
        end
    endtask

    // Driver: applies stimulus and pushes the expected item
    task automatic chk(input bit inst, input logic [11:0] a, input logic [63:0] src, input string tag);
        exp_t e;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = a; src_level = src;
        e.rd = rd_m(inst, a, src); e.irq = irq_m(inst, src); e.inst = inst; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares at the falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            logic [31:0] grd;
            logic        girq;
            e = sb.pop_front();
            grd  = e.inst ? rd_b : rd_a;
            girq = e.inst ? irq_b : irq_a;
            n_cmp++;
            if (grd !== e.rd || girq !== e.irq) begin
                n_bad++;
                $display("FAIL %s inst%0d addr=%h: rdata=%h irq=%b expected rdata=%h irq=%b",
                         e.tag, e.inst, reg_addr, grd, girq, e.rd, e.irq);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 2; k++)
            for (int i = 0; i < 64; i++) cfg_m[k][i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state with all inputs high
        chk(0, 12'h000, '1, "R1");
        chk(0, 12'h0FC, '1, "R1");
        chk(0, 12'h10C, '1, "R1");
        chk(1, 12'h104, '1, "R1");

        // R2: only low 7 bits stored; D1 -> 0x51
        wr(12'h014, 32'hFFFF_FFD1);
        chk(0, 12'h014, '0, "R2");
        chk(1, 12'h014, '0, "R2");
        // R3 / R5: 0x51 enables variant 0 only
        chk(0, 12'h10C, 64'h20, "R5");
        chk(1, 12'h104, 64'h20, "R3");
        // R3: 0x20 enables variant 1 only
        wr(12'h01C, 32'h20);
        chk(1, 12'h104, 64'h80, "R3");
        chk(0, 12'h10C, 64'h80, "R3");
        // R3: one bit off the code stays disabled
        wr(12'h014, 32'h50);
        chk(0, 12'h10C, 64'h20, "R3");

        // R6: lowest-number pick
        wr(12'h000, 32'h51);
        wr(12'h028, 32'h51);
        wr(12'h0A0, 32'h51);
        wr(12'h0FC, 32'h51);
        chk(0, 12'h10C, 64'h8000_0000_0000_0000, "R6");
        chk(0, 12'h10C, 64'h8000_0100_0000_0000, "R6");
        chk(0, 12'h10C, 64'h8000_0100_0000_0400, "R6");
        chk(0, 12'h10C, 64'h8000_0000_0000_0001, "R6");

        // R7 / R8: request follows level in the same cycle
        chk(0, 12'h10C, 64'h0000_0100_0000_0000, "R7");
        chk(0, 12'h10C, 64'h0, "R8");
        chk(0, 12'h10C, 64'h0000_0100_0000_0000, "R8");
        // R10: pending only on disabled sources reads 0
        chk(0, 12'h10C, 64'h0000_0000_0000_0022, "R10");

        // R4: zero write disables source 40
        wr(12'h0A0, 32'h0);
        chk(0, 12'h10C, 64'h0000_0100_0000_0000, "R4");
        chk(0, 12'h0A0, 64'h0000_0100_0000_0000, "R4");

        // R9: writes to selection, past-end and unaligned addresses ignored
        wr(12'h10C, 32'h0);
        wr(12'h104, 32'h0);
        wr(12'h100, 32'h0);
        wr(12'h002, 32'h0);
        chk(0, 12'h000, 64'h1, "R9");
        chk(0, 12'h10C, 64'h1, "R9");
        chk(0, 12'h100, 64'h1, "R9");
        chk(0, 12'h104, 64'h1, "R9");
        chk(1, 12'h10C, 64'h80, "R9");
        chk(1, 12'h01C, 64'h80, "R9");

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule